// File: doc/BRIEF.md
# Serial Flash Control Register Bank

This block is the software-visible register bank of a serial NOR flash controller. It also holds the controller's sector write-protection logic. A simple 32-bit register bus reads and writes seven word registers: status, two device-ID words, a memory-operation command word, a sticky interrupt status word, its mask, and a one-hot chip select.

A write to the command word carries a 2-bit opcode in its low bits and a payload above them. An accepted command becomes a one-cycle request to the serial engine, marks the controller busy, and stays busy until the engine reports completion. A protect command loads a block-protect level and a top/bottom flag into the status word. From those the block computes which sectors are protected.

An erase or data write aimed at a protected sector never reaches the engine. It latches a flag in the interrupt status word, and the interrupt output follows the flags that the mask enables.

Top module: `sfc_regbank`

## Requirements
- R1: After reset the status word reads 0, interrupt status and mask read 0, chip select reads 0x1, the interrupt output is low and no request pulse is issued.
- R2: Reads use byte offsets 0x00 status, 0x04 short ID, 0x08 long ID, 0x10 interrupt status, 0x14 interrupt mask and 0x18 chip select. The status word carries busy in bit 0, write-enable latch in bit 1, protect level bits 2..0 in bits 4:2, top/bottom in bit 5 and protect level bit 3 in bit 6. The ID words return their 8-bit parameters in bits 7:0.
- R3: A write to offset 0x0C with opcode bits 1:0 equal to 1 (bulk erase), 2 (sector erase, sector in bits 17:8) or 3 (protect, payload in bits 12:8) produces op_req high for exactly the one cycle after the write. It also presents op_cmd and op_arg: the sector for an erase, the 5-bit payload for a protect, 0 for bulk. Opcode 0 is ignored.
- R4: An accepted command sets busy and the write-enable latch, and eng_done clears both. A command write while busy has no effect on requests or status.
- R5: An accepted protect command loads the protect level from payload bits 11:8 and top/bottom from bit 12. A zero payload removes all protection.
- R6: With level L>0 and 2^SEC_W sectors, the protected sectors are the top 2^(L-1) when top/bottom is 0 and the bottom 2^(L-1) when it is 1. When 2^(L-1) reaches the sector count, every sector is protected. A level of 0 protects nothing.
- R7: A sector erase aimed at a protected sector, or a bulk erase while any protection is set, issues no request, leaves busy clear and sets interrupt status bit 0.
- R8: A data write (data_wr_valid with data_wr_sector) to an unprotected sector raises data_wr_go for the following cycle. One aimed at a protected sector raises nothing and sets interrupt status bit 1.
- R9: Interrupt status bits stay set until a write of 1 to that bit at offset 0x10. A new event in the same cycle as its clear leaves the bit set.
- R10: irq is high exactly when some interrupt status bit is set whose mask bit (offset 0x14, bit 0 erase, bit 1 write) is 1.
- R11: A chip-select write takes effect only when the written word equals 0x1, 0x2 or 0x4. Any other value leaves chip select unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| op_req | output | 1 | One-cycle command request to the engine |
| op_cmd | output | 2 | Opcode of the request |
| op_arg | output | 10 | Sector or protect payload of the request |
| eng_done | input | 1 | Engine finished the current command |
| data_wr_valid | input | 1 | A data write is being attempted |
| data_wr_sector | input | SEC_W | Target sector of the data write |
| data_wr_go | output | 1 | Data write permitted and forwarded |
| chip_sel | output | NUM_CS | One-hot flash device select |
| irq | output | 1 | Masked interrupt output |

## Verification
The bench builds the block with SEC_W=4, which gives a 16-sector array. At that size every protect level from 0 to 15 is meaningful: levels 1 to 4 give partial regions at both ends, and levels 5 and above cover the whole array. Random protect settings and target sectors therefore hit region edges, full coverage and the unprotected case often. Directed cases cover the busy window, a set and a clear of the same status bit in one cycle, and rejected chip-select values.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

  typedef enum logic [1:0] {
    CMD_NONE    = 2'd0,
    CMD_BULK    = 2'd1,
    CMD_SECTOR  = 2'd2,
    CMD_PROTECT = 2'd3
  } mem_cmd_e;

  localparam int unsigned FIELD_W = 10;

  localparam logic [7:0] OFS_STATUS = 8'h00;
  localparam logic [7:0] OFS_SID    = 8'h04;
  localparam logic [7:0] OFS_LID    = 8'h08;
  localparam logic [7:0] OFS_MEMOP  = 8'h0C;
  localparam logic [7:0] OFS_ISR    = 8'h10;
  localparam logic [7:0] OFS_IMR    = 8'h14;
  localparam logic [7:0] OFS_CSEL   = 8'h18;

  // Protected-region membership for a sector given level and side.
  function automatic logic sector_locked(input logic [FIELD_W-1:0] sector,
                                         input logic [3:0] level,
                                         input logic from_bottom,
                                         input int unsigned sec_w);
    int unsigned span;
    int unsigned total;
    int unsigned idx;
    if (level == 4'd0) return 1'b0;
    if ({28'd0, level} - 32'd1 >= sec_w) return 1'b1;
    span  = 32'd1 << (level - 4'd1);
    total = 32'd1 << sec_w;
    idx   = {22'd0, sector};
    if (from_bottom) return idx < span;
    return idx >= total - span;
  endfunction

  // Status word layout.
  function automatic logic [31:0] pack_status(input logic busy, input logic wel,
                                              input logic [3:0] level,
                                              input logic from_bottom);
    return {25'd0, level[3], from_bottom, level[2:0], wel, busy};
  endfunction

endpackage

// File: rtl/sfc_prot_check.sv
module sfc_prot_check
  import sfc_pkg::*;
#(
  parameter int SEC_W = 10
) (
  input  logic [SEC_W-1:0] sector,
  input  logic [3:0]       level,
  input  logic             from_bottom,
  output logic             locked
);
  logic [FIELD_W-1:0] sector_ext;

  generate
    if (SEC_W == FIELD_W) begin : g_full
      assign sector_ext = sector;
    end else begin : g_pad
      assign sector_ext = {{(FIELD_W-SEC_W){1'b0}}, sector};
    end
  endgenerate

  assign locked = sector_locked(sector_ext, level, from_bottom, SEC_W);
endmodule

// File: rtl/sfc_cmd_decode.sv
module sfc_cmd_decode
  import sfc_pkg::*;
#(
  parameter int SEC_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               memop_wr,
  input  logic [1:0]         opcode,
  input  logic [FIELD_W-1:0] field,
  input  logic               busy,
  input  logic [3:0]         level,
  input  logic               from_bottom,
  output logic               cmd_accept,
  output logic               erase_illegal,
  output logic               protect_load,
  output logic               op_req,
  output logic [1:0]         op_cmd,
  output logic [FIELD_W-1:0] op_arg
);
  mem_cmd_e           cmd;
  logic               tgt_locked;
  logic [FIELD_W-1:0] arg_next;

  assign cmd = mem_cmd_e'(opcode);

  sfc_prot_check #(.SEC_W(SEC_W)) u_erase_chk (
    .sector      (field[SEC_W-1:0]),
    .level       (level),
    .from_bottom (from_bottom),
    .locked      (tgt_locked)
  );

  always_comb begin
    erase_illegal = memop_wr && !busy &&
                    ((cmd == CMD_SECTOR && tgt_locked) ||
                     (cmd == CMD_BULK && level != 4'd0));
    cmd_accept    = memop_wr && !busy && (cmd != CMD_NONE) && !erase_illegal;
    protect_load  = cmd_accept && (cmd == CMD_PROTECT);
    case (cmd)
      CMD_SECTOR:  arg_next = field;
      CMD_PROTECT: arg_next = {{(FIELD_W-5){1'b0}}, field[4:0]};
      default:     arg_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_req <= 1'b0;
      op_cmd <= 2'd0;
      op_arg <= '0;
    end else begin
      op_req <= cmd_accept;
      if (cmd_accept) begin
        op_cmd <= opcode;
        op_arg <= arg_next;
      end
    end
  end
endmodule

// File: rtl/sfc_irq_regs.sv
module sfc_irq_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_erase,
  input  logic       set_write,
  input  logic       isr_wr,
  input  logic       imr_wr,
  input  logic [1:0] wdata,
  output logic [1:0] isr,
  output logic [1:0] imr,
  output logic       irq
);
  logic [1:0] clr_bits;
  logic [1:0] set_bits;

  assign clr_bits = isr_wr ? wdata : 2'b00;
  assign set_bits = {set_write, set_erase};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr <= 2'b00;
      imr <= 2'b00;
    end else begin
      isr <= (isr & ~clr_bits) | set_bits;
      if (imr_wr) imr <= wdata;
    end
  end

  assign irq = |(isr & imr);
endmodule

// File: rtl/sfc_regbank.sv
module sfc_regbank
  import sfc_pkg::*;
#(
  parameter int         SEC_W    = 10,
  parameter int         AW       = 5,
  parameter int         NUM_CS   = 3,
  parameter logic [7:0] SHORT_ID = 8'h14,
  parameter logic [7:0] LONG_ID  = 8'h19
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [AW-1:0]      bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               op_req,
  output logic [1:0]         op_cmd,
  output logic [9:0]         op_arg,
  input  logic               eng_done,
  input  logic               data_wr_valid,
  input  logic [SEC_W-1:0]   data_wr_sector,
  output logic               data_wr_go,
  output logic [NUM_CS-1:0]  chip_sel,
  output logic               irq
);
  localparam logic [AW-1:0] A_STATUS = AW'(OFS_STATUS);
  localparam logic [AW-1:0] A_SID    = AW'(OFS_SID);
  localparam logic [AW-1:0] A_LID    = AW'(OFS_LID);
  localparam logic [AW-1:0] A_MEMOP  = AW'(OFS_MEMOP);
  localparam logic [AW-1:0] A_ISR    = AW'(OFS_ISR);
  localparam logic [AW-1:0] A_IMR    = AW'(OFS_IMR);
  localparam logic [AW-1:0] A_CSEL   = AW'(OFS_CSEL);

  // Named internal events
  logic       wip;
  logic       wel;
  logic [3:0] prot_level;
  logic       prot_bottom;
  logic       cmd_accept;
  logic       erase_illegal;
  logic       write_illegal;
  logic       protect_load;
  logic       data_locked;
  logic       cs_write_ok;
  logic [1:0] isr;
  logic [1:0] imr;

  logic memop_wr;
  logic isr_wr;
  logic imr_wr;
  logic cs_wr;

  assign memop_wr = bus_wr && (bus_addr == A_MEMOP);
  assign isr_wr   = bus_wr && (bus_addr == A_ISR);
  assign imr_wr   = bus_wr && (bus_addr == A_IMR);
  assign cs_wr    = bus_wr && (bus_addr == A_CSEL);

  sfc_cmd_decode #(.SEC_W(SEC_W)) u_decode (
    .clk           (clk),
    .rst_n         (rst_n),
    .memop_wr      (memop_wr),
    .opcode        (bus_wdata[1:0]),
    .field         (bus_wdata[17:8]),
    .busy          (wip),
    .level         (prot_level),
    .from_bottom   (prot_bottom),
    .cmd_accept    (cmd_accept),
    .erase_illegal (erase_illegal),
    .protect_load  (protect_load),
    .op_req        (op_req),
    .op_cmd        (op_cmd),
    .op_arg        (op_arg)
  );

  // Status: busy, write-enable latch and protection setting
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wip         <= 1'b0;
      wel         <= 1'b0;
      prot_level  <= 4'd0;
      prot_bottom <= 1'b0;
    end else begin
      if (cmd_accept) begin
        wip <= 1'b1;
        wel <= 1'b1;
      end else if (eng_done) begin
        wip <= 1'b0;
        wel <= 1'b0;
      end
      if (protect_load) begin
        prot_level  <= bus_wdata[11:8];
        prot_bottom <= bus_wdata[12];
      end
    end
  end

  // Data write gate
  sfc_prot_check #(.SEC_W(SEC_W)) u_data_chk (
    .sector      (data_wr_sector),
    .level       (prot_level),
    .from_bottom (prot_bottom),
    .locked      (data_locked)
  );

  assign write_illegal = data_wr_valid && data_locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_wr_go <= 1'b0;
    else        data_wr_go <= data_wr_valid && !data_locked;
  end

  sfc_irq_regs u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_erase (erase_illegal),
    .set_write (write_illegal),
    .isr_wr    (isr_wr),
    .imr_wr    (imr_wr),
    .wdata     (bus_wdata[1:0]),
    .isr       (isr),
    .imr       (imr),
    .irq       (irq)
  );

  // Chip select: only a single-bit value within range is taken
  assign cs_write_ok = $onehot(bus_wdata[NUM_CS-1:0]) &&
                       (bus_wdata[31:NUM_CS] == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    chip_sel <= NUM_CS'(1);
    else if (cs_wr && cs_write_ok) chip_sel <= bus_wdata[NUM_CS-1:0];
  end

  // Read mux
  always_comb begin
    bus_rdata = 32'd0;
    case (bus_addr)
      A_STATUS: bus_rdata = pack_status(wip, wel, prot_level, prot_bottom);
      A_SID:    bus_rdata = {24'd0, SHORT_ID};
      A_LID:    bus_rdata = {24'd0, LONG_ID};
      A_ISR:    bus_rdata = {30'd0, isr};
      A_IMR:    bus_rdata = {30'd0, imr};
      A_CSEL:   bus_rdata = {{(32-NUM_CS){1'b0}}, chip_sel};
      default:  bus_rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/sfc_regbank_chk.sv
module sfc_regbank_chk #(
  parameter int AW     = 5,
  parameter int NUM_CS = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [AW-1:0]     bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              op_req,
  input logic              eng_done,
  input logic              data_wr_valid,
  input logic              data_wr_go,
  input logic [NUM_CS-1:0] chip_sel,
  input logic              irq,
  input logic              wip,
  input logic              cmd_accept,
  input logic              erase_illegal,
  input logic              write_illegal,
  input logic [1:0]        isr,
  input logic [1:0]        imr
);
  localparam logic [AW-1:0] A_MEMOP = AW'(8'h0C);
  localparam logic [AW-1:0] A_ISR   = AW'(8'h10);

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    op_req |=> !op_req); // R3
  AST_REQ_MARKS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    op_req |-> wip); // R4
  AST_BUSY_BLOCKS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_MEMOP && wip) |=> !op_req); // R4
  AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && wip && !cmd_accept) |=> !wip); // R4
  AST_BAD_ERASE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    erase_illegal |=> (isr[0] && !op_req)); // R7
  AST_BAD_WRITE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    write_illegal |=> (isr[1] && !data_wr_go)); // R8
  AST_GOOD_WRITE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr_valid && !write_illegal) |=> data_wr_go); // R8
  AST_ISR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (isr[0] && !(bus_wr && bus_addr == A_ISR && bus_wdata[0])) |=> isr[0]); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (imr == 2'b00) |-> !irq); // R10
  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(chip_sel)); // R11
endmodule

bind sfc_regbank sfc_regbank_chk #(.AW(AW), .NUM_CS(NUM_CS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_wr        (bus_wr),
  .bus_addr      (bus_addr),
  .bus_wdata     (bus_wdata),
  .op_req        (op_req),
  .eng_done      (eng_done),
  .data_wr_valid (data_wr_valid),
  .data_wr_go    (data_wr_go),
  .chip_sel      (chip_sel),
  .irq           (irq),
  .wip           (wip),
  .cmd_accept    (cmd_accept),
  .erase_illegal (erase_illegal),
  .write_illegal (write_illegal),
  .isr           (isr),
  .imr           (imr)
);

// File: tb/tb_sfc_regbank.sv
module tb_sfc_regbank;
  localparam int SEC_W = 4;
  localparam int NSEC  = 16;
  localparam int AW    = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             bus_wr = 1'b0;
  logic [AW-1:0]    bus_addr = '0;
  logic [31:0]      bus_wdata = '0;
  logic [31:0]      bus_rdata;
  logic             op_req;
  logic [1:0]       op_cmd;
  logic [9:0]       op_arg;
  logic             eng_done = 1'b0;
  logic             data_wr_valid = 1'b0;
  logic [SEC_W-1:0] data_wr_sector = '0;
  logic             data_wr_go;
  logic [2:0]       chip_sel;
  logic             irq;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sfc_regbank #(.SEC_W(SEC_W), .AW(AW), .NUM_CS(3),
                .SHORT_ID(8'h14), .LONG_ID(8'h19)) dut (.*);

  // Expected-value helpers
  function automatic bit exp_locked(int s, int lvl, bit bottom);
    int cnt;
    if (lvl == 0) return 0;
    cnt = (lvl - 1 >= SEC_W) ? NSEC : (1 << (lvl - 1));
    if (bottom) return (s < cnt);
    return (s > NSEC - 1 - cnt);
  endfunction

  function automatic logic [31:0] exp_status(bit busy, int lvl, bit bottom);
    logic [31:0] v;
    v = 0;
    if (busy) v = v | 32'h3;
    v = v | ((lvl & 7) << 2);
    if (bottom) v = v | 32'h20;
    if (lvl >= 8) v = v | 32'h40;
    return v;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a[AW-1:0]; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a[AW-1:0];
    #1;
    d = bus_rdata;
  endtask

  task automatic dwrite(int s);
    @(negedge clk);
    data_wr_valid = 1'b1; data_wr_sector = SEC_W'(s);
    @(negedge clk);
    data_wr_valid = 1'b0;
  endtask

  task automatic finish_op();
    @(negedge clk);
    eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      report();
    end
  end

  initial begin
    logic [31:0] v;
    int lvl;
    bit bottom;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h00, v); chk("R1 status", v, 0);
    rd(8'h10, v); chk("R1 isr", v, 0);
    rd(8'h14, v); chk("R1 imr", v, 0);
    rd(8'h18, v); chk("R1 cs", v, 1);
    chk("R1 irq", irq, 0);
    chk("R1 op_req", op_req, 0);
    // R2 ID words
    rd(8'h04, v); chk("R2 short id", v, 32'h14);
    rd(8'h08, v); chk("R2 long id", v, 32'h19);

    // R3 opcode 0 ignored
    wr(8'h0C, 32'h0);
    chk("R3 nop no req", op_req, 0);
    rd(8'h00, v); chk("R3 nop status", v, 0);

    // R3 R4 bulk erase with no protection
    wr(8'h0C, 32'h1);
    chk("R3 bulk req", op_req, 1);
    chk("R3 bulk cmd", op_cmd, 1);
    rd(8'h00, v); chk("R4 busy set", v, 3);
    @(negedge clk);
    chk("R3 req one cycle", op_req, 0);
    // R4 write while busy ignored
    wr(8'h0C, 32'h0000_0503);
    chk("R4 busy ignore req", op_req, 0);
    rd(8'h00, v); chk("R4 busy ignore status", v, 3);
    finish_op();
    rd(8'h00, v); chk("R4 done clears", v, 0);

    // R5 protect bottom two sectors (level 2)
    wr(8'h0C, 32'h0000_1203);
    chk("R3 protect req", op_req, 1);
    chk("R3 protect cmd", op_cmd, 3);
    chk("R3 protect arg", op_arg, 10'h12);
    rd(8'h00, v); chk("R5 status load", v, 32'h2B);
    finish_op();
    rd(8'h00, v); chk("R5 status idle", v, 32'h28);

    // R7 erase of protected sector 1
    wr(8'h0C, 32'h0000_0102);
    chk("R7 no req", op_req, 0);
    rd(8'h10, v); chk("R7 isr", v, 1);
    rd(8'h00, v); chk("R7 not busy", v, 32'h28);
    chk("R10 masked irq", irq, 0);
    wr(8'h14, 32'h1);
    chk("R10 irq enabled", irq, 1);

    // R6 sector 2 is just outside region
    wr(8'h0C, 32'h0000_0202);
    chk("R6 edge req", op_req, 1);
    chk("R3 sector arg", op_arg, 10'd2);
    finish_op();

    // R7 bulk erase while protected
    wr(8'h0C, 32'h1);
    chk("R7 bulk blocked", op_req, 0);

    // R8 data writes
    dwrite(0);
    chk("R8 blocked go", data_wr_go, 0);
    rd(8'h10, v); chk("R8 isr", v, 3);
    dwrite(9);
    chk("R8 allowed go", data_wr_go, 1);

    // R9 write-one-to-clear
    wr(8'h10, 32'h1);
    rd(8'h10, v); chk("R9 w1c", v, 2);
    chk("R10 irq off", irq, 0);
    wr(8'h14, 32'h2);
    chk("R10 irq write bit", irq, 1);
    // R9 set wins over clear
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 5'h10; bus_wdata = 32'h2;
    data_wr_valid = 1'b1; data_wr_sector = 4'd0;
    @(negedge clk);
    bus_wr = 1'b0; data_wr_valid = 1'b0;
    rd(8'h10, v); chk("R9 set wins", v, 2);
    wr(8'h10, 32'h3);
    rd(8'h10, v); chk("R9 cleared", v, 0);

    // R5 zero payload removes protection
    wr(8'h0C, 32'h3);
    rd(8'h00, v); chk("R5 unprotect", v, 3);
    finish_op();
    dwrite(0);
    chk("R5 sector 0 free", data_wr_go, 1);

    // R11 chip select
    wr(8'h18, 32'h2); rd(8'h18, v); chk("R11 cs 2", v, 2);
    wr(8'h18, 32'h3); rd(8'h18, v); chk("R11 cs reject 3", v, 2);
    wr(8'h18, 32'h0); rd(8'h18, v); chk("R11 cs reject 0", v, 2);
    wr(8'h18, 32'h8); rd(8'h18, v); chk("R11 cs reject 8", v, 2);
    wr(8'h18, 32'h4); rd(8'h18, v); chk("R11 cs 4", v, 4);

    // Random protection/erase/write mix (R6 R7 R8)
    void'($urandom(32'd1234));
    wr(8'h14, 32'h3);
    for (int it = 0; it < 150; it++) begin
      int s;
      bit lk;
      lvl = $urandom % 16;
      bottom = $urandom % 2;
      wr(8'h0C, 32'h3 | (lvl << 8) | (32'(bottom) << 12));
      chk("R5 rand protect req", op_req, 1);
      finish_op();
      rd(8'h00, v); chk("R5 rand status", v, exp_status(0, lvl, bottom));
      s = $urandom % NSEC;
      lk = exp_locked(s, lvl, bottom);
      wr(8'h0C, 32'h2 | (s << 8));
      chk("R6 rand erase req", op_req, !lk);
      if (!lk) begin
        chk("R3 rand erase arg", op_arg, 10'(s));
        finish_op();
      end
      rd(8'h10, v); chk("R7 rand isr", v, {31'd0, lk});
      chk("R10 rand irq", irq, lk);
      s = $urandom % NSEC;
      lk = exp_locked(s, lvl, bottom);
      dwrite(s);
      chk("R8 rand go", data_wr_go, !lk);
      rd(8'h10, v); chk("R8 rand isr", v[1], lk);
      wr(8'h10, 32'h3);
    end

    finished = 1;
    report();
  end
endmodule